// File: doc/BRIEF.md
# I/O Port to Three-Wire Serial Bridge

This block gives a CPU access to a serial clock-calendar device, or to other serial devices, through three consecutive I/O ports. The CPU writes a device number into the select port and a register number into the address port. It then reads or writes the data port. A data-port access starts a serial transaction on a clock line, a one-hot chip-select bus and a single data line that carries traffic in both directions.

During the transaction the bridge holds the CPU with a wait signal. A read returns the byte that was shifted in. A write sends the byte from the bus. The data line is split into output, output-enable and input pins, and the pad that joins them sits outside the block. Each SCK half-period lasts `HALF` clock cycles. The ports sit at `BASE`, `BASE+1` and `BASE+2`.

Top module: `ioSerialBridge`

## Requirements
- R1: After reset, ioWait, csOut, sck and sdaOe are all low, ioRdData is 00h, and the select and address ports hold 00h.
- R2: A write to offset 0 (select) or offset 1 (address) stores the byte. A read of either offset loads that byte into ioRdData on the clock edge that samples the strobe.
- R3: A data-port access (offset 2) with select value below NUM_CS does two things from the sampling edge on: it drives csOut[select] and ioWait high for 33*HALF cycles, and only that chip-select bit is high. SCK idles low. SCK gives 16 pulses, each HALF cycles low followed by HALF cycles high. After the last pulse there is a HALF-cycle low tail before chip-select drops.
- R4: The first 8 serial bits form the command byte and go out LSB first. Bit 0 is the direction flag (1 = read, 0 = write), and bits 7:1 are address-port bits 6:0. Each bit appears at the start of its SCK low phase and is held through the high phase.
- R5: On a write, the 8 bits that follow the command are ioWrData, sent LSB first. sdaOe stays high until chip-select drops.
- R6: On a read, sdaOe falls at the start of the low phase after the 8th command bit and stays low. sdaIn is sampled as each of the last 8 SCK pulses rises, LSB first. The assembled byte appears on ioRdData on the edge where ioWait falls.
- R7: A data-port access with select value of NUM_CS or more starts no transaction and raises no wait. A read loads FFh into ioRdData. A write has no effect.
- R8: Any port access made while ioWait is high is ignored, including writes to the select and address ports.
- R9: Accesses to addresses outside BASE..BASE+2 are ignored: no wait, no serial activity, and ioRdData does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioAddr | input | 8 | CPU I/O address |
| ioWrData | input | 8 | CPU write data |
| ioRd | input | 1 | One-cycle I/O read strobe |
| ioWr | input | 1 | One-cycle I/O write strobe |
| ioRdData | output | 8 | Read data returned to the CPU |
| ioWait | output | 1 | Holds the CPU while a serial transaction runs |
| sck | output | 1 | Serial clock, idles low |
| csOut | output | NUM_CS | One-hot chip selects, active high |
| sdaOut | output | 1 | Serial data value driven by the bridge |
| sdaOe | output | 1 | Output enable for the serial data pad |
| sdaIn | input | 1 | Serial data value seen at the pad |

## Verification
The hardest case to reach is a CPU access that arrives in the middle of a running transaction. A CPU that honours the wait signal never produces one. The bench therefore ignores ioWait on purpose: it starts a write, pulses an address-port write a few cycles later, and then reads the address port back to show that the old value survived. A device model on the serial pins stores written bytes and returns them on later reads, which closes the loop between the write and read directions.

// File: rtl/ioSerialBridgePkg.sv
package ioSerialBridgePkg;
  // Sequencer events consumed by the datapath
  typedef struct packed {
    logic load;    // capture command and data into the shifter
    logic shift;   // present the next serial bit
    logic sample;  // capture one incoming bit
    logic turn;    // release the data line for the read phase
    logic finish;  // transaction complete
  } seqStrobes_t;

  localparam int FRAME_BITS = 16;
endpackage

// File: rtl/ioSerialBridgeCtrl.sv
module ioSerialBridgeCtrl
  import ioSerialBridgePkg::*;
#(
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        go,
  input  logic        goRead,
  output seqStrobes_t ctl,
  output logic        busy,
  output logic        csActive,
  output logic        sck
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] CMD_LAST = BW'(7);

  typedef enum logic [1:0] {IDLE, RUN, TAIL} seqState_t;

  seqState_t state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitIdx;
  logic readMode;
  logic lastCnt;

  assign lastCnt = (cnt == CW'(HALF - 1));

  always_comb begin
    ctl        = '0;
    ctl.load   = (state == IDLE) && go;
    ctl.shift  = (state == RUN) && lastCnt && sck && (bitIdx != LAST_BIT);
    ctl.sample = (state == RUN) && lastCnt && !sck && readMode && bitIdx[BW-1];
    ctl.turn   = ctl.shift && readMode && (bitIdx == CMD_LAST);
    ctl.finish = (state == TAIL) && lastCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      readMode <= 1'b0;
      busy     <= 1'b0;
      csActive <= 1'b0;
      sck      <= 1'b0;
    end else begin
      unique case (state)
        IDLE: if (go) begin
          state    <= RUN;
          cnt      <= '0;
          bitIdx   <= '0;
          readMode <= goRead;
          busy     <= 1'b1;
          csActive <= 1'b1;
          sck      <= 1'b0;
        end
        RUN: begin
          if (lastCnt) begin
            cnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (bitIdx == LAST_BIT) state <= TAIL;
              else bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TAIL: begin
          if (lastCnt) begin
            state    <= IDLE;
            busy     <= 1'b0;
            csActive <= 1'b0;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ioSerialBridgeDatapath.sv
module ioSerialBridgeDatapath
  import ioSerialBridgePkg::*;
#(
  parameter int BASE   = 0,
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              busy,
  input  logic              csActive,
  input  seqStrobes_t       ctl,
  input  logic              sdaIn,
  output logic              go,
  output logic              goRead,
  output logic [7:0]        ioRdData,
  output logic [NUM_CS-1:0] csOut,
  output logic              sdaOut,
  output logic              sdaOe
);
  localparam int SW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [7:0] devSel;
  logic [7:0] regAddr;
  logic [7:0] offset;
  logic       hit;
  logic       access;
  logic       devValid;
  logic [SW-1:0] selLatch;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [7:0] rxReg;
  logic       rdFlag;

  assign offset   = ioAddr - 8'(BASE);
  assign hit      = (offset < 8'd3);
  assign access   = !busy && hit && (ioRd || ioWr);
  assign devValid = (devSel < 8'(NUM_CS));
  assign go       = access && (offset == 8'd2) && devValid;
  assign goRead   = !ioWr;
  assign sdaOut   = shiftReg[0];

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign csOut[i] = csActive && (selLatch == SW'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devSel   <= '0;
      regAddr  <= '0;
      ioRdData <= '0;
      selLatch <= '0;
      shiftReg <= '0;
      rxReg    <= '0;
      rdFlag   <= 1'b0;
      sdaOe    <= 1'b0;
    end else begin
      if (access && ioWr) begin
        if (offset == 8'd0) devSel  <= ioWrData;
        if (offset == 8'd1) regAddr <= ioWrData;
      end else if (access && ioRd) begin
        if (offset == 8'd0) ioRdData <= devSel;
        if (offset == 8'd1) ioRdData <= regAddr;
        if (offset == 8'd2 && !devValid) ioRdData <= 8'hFF;
      end
      if (ctl.load) begin
        shiftReg <= {ioWrData, regAddr[6:0], goRead};
        selLatch <= SW'(devSel);
        rdFlag   <= goRead;
        sdaOe    <= 1'b1;
      end else if (ctl.shift) begin
        shiftReg <= {1'b0, shiftReg[FRAME_BITS-1:1]};
      end
      if (ctl.turn) sdaOe <= 1'b0;
      if (ctl.sample) rxReg <= {sdaIn, rxReg[7:1]};
      if (ctl.finish) begin
        sdaOe <= 1'b0;
        if (rdFlag) ioRdData <= rxReg;
      end
    end
  end
endmodule

// File: rtl/ioSerialBridge.sv
module ioSerialBridge
  import ioSerialBridgePkg::*;
#(
  parameter int BASE   = 0,
  parameter int NUM_CS = 2,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioRd,
  input  logic              ioWr,
  output logic [7:0]        ioRdData,
  output logic              ioWait,
  output logic              sck,
  output logic [NUM_CS-1:0] csOut,
  output logic              sdaOut,
  output logic              sdaOe,
  input  logic              sdaIn
);
  seqStrobes_t ctl;
  logic go, goRead, busy, csActive;

  assign ioWait = busy;

  ioSerialBridgeCtrl #(.HALF(HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .goRead(goRead), .ctl(ctl),
    .busy(busy), .csActive(csActive), .sck(sck)
  );

  ioSerialBridgeDatapath #(.BASE(BASE), .NUM_CS(NUM_CS)) u_dp (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRd(ioRd), .ioWr(ioWr), .busy(busy), .csActive(csActive), .ctl(ctl),
    .sdaIn(sdaIn), .go(go), .goRead(goRead), .ioRdData(ioRdData),
    .csOut(csOut), .sdaOut(sdaOut), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/ioSerialBridgeChk.sv
module ioSerialBridgeChk #(
  parameter int BASE   = 0,
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic              ioWait,
  input logic              sck,
  input logic [NUM_CS-1:0] csOut,
  input logic              sdaOut,
  input logic              sdaOe
);
  // R3
  cs_tracks_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|csOut) == ioWait);
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csOut));
  // R3
  sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> (|csOut));
  // R4
  sda_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe && $rose(sck)) |-> $stable(sdaOut));
  // R7
  wait_from_data_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioWait) |-> ($past(ioRd || ioWr) && ($past(ioAddr) == 8'(BASE + 2))));
  // R6
  oe_only_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $rose(ioWait));
endmodule

bind ioSerialBridge ioSerialBridgeChk #(.BASE(BASE), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
  .ioWait(ioWait), .sck(sck), .csOut(csOut), .sdaOut(sdaOut), .sdaOe(sdaOe)
);

// File: tb/ioSerialBridge_tb.sv
`timescale 1ns/1ps
module ioSerialBridge_tb;
  localparam int BASE = 0;
  localparam int NCS  = 2;
  localparam int H    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ioAddr = '0, ioWrData = '0;
  logic ioRd = 1'b0, ioWr = 1'b0;
  logic [7:0] ioRdData;
  logic ioWait, sck, sdaOut, sdaOe;
  logic [NCS-1:0] csOut;
  logic sdaIn = 1'b1;

  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  ioSerialBridge #(.BASE(BASE), .NUM_CS(NCS), .HALF(H)) u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRd(ioRd), .ioWr(ioWr), .ioRdData(ioRdData), .ioWait(ioWait),
    .sck(sck), .csOut(csOut), .sdaOut(sdaOut), .sdaOe(sdaOe), .sdaIn(sdaIn)
  );

  // ---------------- serial device model on select 0 ----------------
  logic [7:0] devMem [128];
  logic [7:0] dCmd, dWr;
  int dCnt = 0;
  initial for (int i = 0; i < 128; i++) devMem[i] = 8'(i * 37 + 5);

  always @(posedge sck) if (csOut[0]) begin
    if (dCnt < 8) dCmd[dCnt] = sdaOut;
    else if (dCnt < 16 && !dCmd[0]) dWr[dCnt-8] = sdaOut;
    dCnt++;
  end
  always @(negedge sck) if (csOut[0] && dCmd[0] && dCnt >= 8 && dCnt < 16)
    sdaIn = devMem[dCmd[7:1]][dCnt-8];
  always @(negedge csOut[0]) begin
    if (dCnt == 16 && !dCmd[0]) devMem[dCmd[7:1]] = dWr;
    dCnt = 0;
    sdaIn = 1'b1;
  end

  // ---------------- cycle reference model ----------------
  int k = -1;
  bit mRead;
  int mSel;
  logic [7:0] mDev = 0, mAddr = 0, mRd = 0, mExpRx;
  logic [15:0] mWord;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      k = -1; mDev = 0; mAddr = 0; mRd = 0;
    end else if (k >= 0) begin
      k++;
      if (k == 33*H) begin
        k = -1;
        if (mRead) mRd = mExpRx;
      end
    end else if (ioRd || ioWr) begin
      logic [7:0] off;
      off = ioAddr - 8'(BASE);
      if (off < 3) begin
        if (ioWr) begin
          if (off == 0) mDev = ioWrData;
          if (off == 1) mAddr = ioWrData;
        end else begin
          if (off == 0) mRd = mDev;
          if (off == 1) mRd = mAddr;
          if (off == 2 && mDev >= NCS) mRd = 8'hFF;
        end
        if (off == 2 && mDev < NCS) begin
          k = 0;
          mRead = !ioWr;
          mSel = int'(mDev);
          mWord = {ioWrData, mAddr[6:0], mRead};
          mExpRx = (mSel == 0) ? devMem[mAddr[6:0]] : 8'hFF;
        end
      end
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    logic [NCS-1:0] eCs;
    bit eSck, eOe, act;
    int bp;
    act = (k >= 0);
    eCs = '0;
    if (act) eCs[mSel] = 1'b1;
    eSck = act && k < 32*H && (k % (2*H)) >= H;
    eOe  = act && (!mRead || k < 16*H);
    compared++;
    cmp("R3", "ioWait", ioWait, act);
    cmp("R3", "csOut", csOut, eCs);
    cmp("R3", "sck", sck, eSck);
    cmp("R6", "sdaOe", sdaOe, eOe);
    cmp("R2", "ioRdData", ioRdData, mRd);
    if (eOe) begin
      bp = (k < 32*H) ? k / (2*H) : 15;
      cmp(bp < 8 ? "R4" : "R5", "sdaOut", sdaOut, mWord[bp]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse(input logic [7:0] a, input logic [7:0] d, input bit wr);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = wr; ioRd = !wr;
    @(negedge clk);
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic access(input logic [7:0] a, input logic [7:0] d, input bit wr,
                        output logic [7:0] r);
    pulse(a, d, wr);
    while (ioWait) @(negedge clk);
    r = ioRdData;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    cmp(req, "value", act, exp);
  endtask

  bit finished = 0;

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", {ioWait, sck, sdaOe, csOut}, 0);
    chk("R1", ioRdData, 0);
    rstN = 1'b1;
    access(8'(BASE+0), 0, 0, r); chk("R1", r, 0);
    // R2
    access(8'(BASE+0), 8'h00, 1, r);
    access(8'(BASE+1), 8'h15, 1, r);
    access(8'(BASE+1), 0, 0, r); chk("R2", r, 8'h15);
    access(8'(BASE+0), 0, 0, r); chk("R2", r, 8'h00);
    // R5 write then R6 read back
    access(8'(BASE+2), 8'hA5, 1, r);
    chk("R5", devMem[8'h15], 8'hA5);
    access(8'(BASE+2), 0, 0, r); chk("R6", r, 8'hA5);
    // R4 address bit 7 dropped from the command
    access(8'(BASE+1), 8'h83, 1, r);
    access(8'(BASE+2), 0, 0, r); chk("R4", r, 8'(3*37+5));
    access(8'(BASE+1), 8'h7F, 1, r);
    access(8'(BASE+2), 8'h3C, 1, r);
    access(8'(BASE+2), 0, 0, r); chk("R6", r, 8'h3C);
    // R3 second select with no device answering
    access(8'(BASE+0), 8'h01, 1, r);
    access(8'(BASE+2), 0, 0, r); chk("R3", r, 8'hFF);
    // R7 out of range select
    access(8'(BASE+0), 8'h05, 1, r);
    access(8'(BASE+1), 8'h15, 1, r);
    access(8'(BASE+2), 8'h99, 1, r); chk("R7", ioWait, 0);
    access(8'(BASE+2), 0, 0, r); chk("R7", r, 8'hFF);
    access(8'(BASE+0), 8'h00, 1, r);
    access(8'(BASE+2), 0, 0, r); chk("R7", r, 8'hA5);
    // R8 access during a running transfer
    pulse(8'(BASE+2), 8'h5A, 1);
    repeat (6) @(negedge clk);
    pulse(8'(BASE+1), 8'h44, 1);
    pulse(8'(BASE+0), 8'h01, 1);
    while (ioWait) @(negedge clk);
    access(8'(BASE+1), 0, 0, r); chk("R8", r, 8'h15);
    access(8'(BASE+0), 0, 0, r); chk("R8", r, 8'h00);
    chk("R8", devMem[8'h15], 8'h5A);
    // R9 unmapped addresses
    access(8'(BASE+3), 0, 0, r); chk("R9", r, 8'h00);
    access(8'h40, 8'h11, 1, r); chk("R9", ioWait, 0);
    access(8'hFF, 0, 0, r); chk("R9", r, 8'h00);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule